// File: doc/BRIEF.md
# Keyboard Command Sender (Host Side)

This block is the host end of a three-wire keyboard link when the host pushes a short command to the keyboard. The host owns two open lines, a data line and a strobe line, and watches one return line from the keyboard. That return line is high when the keyboard is ready and is also used for its acknowledge and its parity verdict. Local logic loads a 4-bit command and pulses start. The block then runs the whole handshake and reports the outcome through a one-cycle done pulse and two status flags.

A transfer has these steps. The block waits, with a time limit, for the keyboard to be ready. It pulls both lines low to interrupt the keyboard, and after a fixed delay it confirms that the keyboard has pulled its line low. It then strobes out five bits: the command, most significant bit first, followed by an odd-parity bit. Next it raises the strobe to read the keyboard's parity verdict, and it closes with one short low pulse on the strobe. The return line reaches the control logic through a two-flop synchronizer. The status flags keep their value until the next accepted start.

Top module: `kbd_cmd_tx`

## Requirements
- R1: After reset, and whenever no transfer is running, the data line and the strobe line are both high, busy is low, and done is low. Both status flags are low after reset.
- R2: After an accepted start, the block waits up to READY_TO_CYC cycles for the return line to be high. If it is still low when that time runs out, the block raises the keyboard-error flag, pulses done, and never lowers the strobe.
- R3: Once the keyboard is ready, the data line and the strobe line fall in the same cycle and stay low for ACK_DLY_CYC cycles. If the synchronized return line is not low at the end of that window, the keyboard-error flag is set, both lines return high, and done pulses.
- R4: Each frame bit is put on the data line while the strobe is high for PHASE_CYC cycles. The strobe is then low for PHASE_CYC cycles, and the data line does not change until the next rise. The keyboard takes the bit on the strobe's falling edge.
- R5: The frame has five bits, sent in this order: cmd[3], cmd[2], cmd[1], cmd[0], then a parity bit that makes the total number of ones in the frame odd.
- R6: After the fifth low phase, the strobe is high for PHASE_CYC cycles with the data line high. The return line is sampled at the end of that phase. Low sets the parity-error flag (value 1); high leaves it at 0.
- R7: To close, the strobe is low for PHASE_CYC cycles and then returns high. Done is high for exactly one cycle at the end of every transfer, and busy is low after it.
- R8: Both status flags keep their value after done until the next accepted start, which clears them. A start pulse while busy is high is ignored, and the frame already in progress is sent unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | One-cycle request to send cmd_i |
| cmd_i | input | DATA_W | Command bits, sampled when start is accepted |
| kbd_rdy_i | input | 1 | Return line from the keyboard (ready, acknowledge, verdict), asynchronous |
| link_data_o | output | 1 | Data line to the keyboard |
| link_strobe_o | output | 1 | Strobe line to the keyboard |
| busy_o | output | 1 | High while a transfer runs |
| done_o | output | 1 | One-cycle pulse when a transfer ends |
| kbd_err_o | output | 1 | Keyboard not ready in time, or no acknowledge |
| par_err_o | output | 1 | Keyboard reported a parity error |

## Verification
The assertions check the following on every cycle:
- the idle line levels
- both lines low throughout the interrupt window
- data held steady while the strobe is low
- the data line high during the verdict phase
- the single-cycle done pulse
- the odd parity of each loaded frame

Only the bench scenarios can show end-to-end behaviour. These are the bit order the keyboard actually receives, the exact length of each strobe phase, the ready timeout, the missing acknowledge, a forced parity verdict, flags that persist, and a start that is ignored during a transfer.

// File: rtl/kct_pkg.sv
package kct_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_RDY,
    ST_INTR,
    ST_BIT_HI,
    ST_BIT_LO,
    ST_VERDICT,
    ST_CLOSE,
    ST_DONE
  } kct_state_e;

  function automatic int unsigned kct_max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/kct_sync.sv
module kct_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic d;
    logic q;
    if (g == 0) begin : g_first
      assign d = async_i;
    end else begin : g_next
      assign d = g_stage[g-1].q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= d;
    end
  end

  assign sync_o = g_stage[STAGES-1].q;

endmodule

// File: rtl/kct_timer.sv
module kct_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = val_i;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/kct_frame.sv
module kct_frame #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [W-2:0] cmd_i,
  output logic         bit_next_o,
  output logic         last_o
);

  localparam int LW = $clog2(W);

  logic [W-1:0]  frame_q, frame_d;
  logic [LW-1:0] left_q, left_d;
  logic          en;

  assign en = load_i | shift_i;

  always_comb begin
    frame_d = frame_q;
    left_d  = left_q;
    if (load_i) begin
      frame_d = {cmd_i, ~(^cmd_i)};
      left_d  = LW'(W - 1);
    end else if (shift_i) begin
      frame_d = {frame_q[W-2:0], 1'b0};
      left_d  = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      left_q  <= '0;
    end else if (en) begin
      frame_q <= frame_d;
      left_q  <= left_d;
    end
  end

  assign bit_next_o = frame_d[W-1];
  assign last_o     = (left_q == '0);

  // R5: a freshly loaded frame carries an odd number of ones
  p_frame_odd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (($countones(frame_q) % 2) == 1));

  // R5: the controller never shifts beyond the fifth bit
  p_no_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !load_i) |-> (left_q != '0));

endmodule

// File: rtl/kct_ctrl.sv
module kct_ctrl
  import kct_pkg::*;
#(
  parameter int READY_TO_CYC = 1000,
  parameter int ACK_DLY_CYC  = 100,
  parameter int PHASE_CYC    = 10,
  parameter int TMR_W        = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             rdy_s_i,
  input  logic             tmr_expired_i,
  input  logic             bit_next_i,
  input  logic             last_bit_i,
  output logic             tmr_load_o,
  output logic [TMR_W-1:0] tmr_val_o,
  output logic             frame_load_o,
  output logic             frame_shift_o,
  output logic             link_data_o,
  output logic             link_strobe_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             kbd_err_o,
  output logic             par_err_o
);

  localparam logic [TMR_W-1:0] RDY_LD   = TMR_W'(READY_TO_CYC - 1);
  localparam logic [TMR_W-1:0] ACK_LD   = TMR_W'(ACK_DLY_CYC - 1);
  localparam logic [TMR_W-1:0] PHASE_LD = TMR_W'(PHASE_CYC - 1);

  kct_state_e state_q, state_d;
  logic kerr_q, kerr_d;
  logic perr_q, perr_d;
  logic data_q, data_d;
  logic strb_q, strb_d;
  logic busy_q, busy_d;
  logic done_q, done_d;

  // next-state process
  always_comb begin
    state_d       = state_q;
    kerr_d        = kerr_q;
    perr_d        = perr_q;
    tmr_load_o    = 1'b0;
    tmr_val_o     = PHASE_LD;
    frame_load_o  = 1'b0;
    frame_shift_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          frame_load_o = 1'b1;
          tmr_load_o   = 1'b1;
          tmr_val_o    = RDY_LD;
          kerr_d       = 1'b0;
          perr_d       = 1'b0;
          state_d      = ST_WAIT_RDY;
        end
      end
      ST_WAIT_RDY: begin
        if (rdy_s_i) begin
          tmr_load_o = 1'b1;
          tmr_val_o  = ACK_LD;
          state_d    = ST_INTR;
        end else if (tmr_expired_i) begin
          kerr_d  = 1'b1;
          state_d = ST_DONE;
        end
      end
      ST_INTR: begin
        if (tmr_expired_i) begin
          if (!rdy_s_i) begin
            tmr_load_o = 1'b1;
            state_d    = ST_BIT_HI;
          end else begin
            kerr_d  = 1'b1;
            state_d = ST_DONE;
          end
        end
      end
      ST_BIT_HI: begin
        if (tmr_expired_i) begin
          tmr_load_o = 1'b1;
          state_d    = ST_BIT_LO;
        end
      end
      ST_BIT_LO: begin
        if (tmr_expired_i) begin
          tmr_load_o = 1'b1;
          if (last_bit_i) begin
            state_d = ST_VERDICT;
          end else begin
            frame_shift_o = 1'b1;
            state_d       = ST_BIT_HI;
          end
        end
      end
      ST_VERDICT: begin
        if (tmr_expired_i) begin
          perr_d     = ~rdy_s_i;
          tmr_load_o = 1'b1;
          state_d    = ST_CLOSE;
        end
      end
      ST_CLOSE: begin
        if (tmr_expired_i) state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // line levels follow the state being entered, so outputs come straight from flops
  always_comb begin
    strb_d = 1'b1;
    data_d = 1'b1;
    unique case (state_d)
      ST_INTR:   begin strb_d = 1'b0; data_d = 1'b0;       end
      ST_BIT_HI: begin strb_d = 1'b1; data_d = bit_next_i; end
      ST_BIT_LO: begin strb_d = 1'b0; data_d = bit_next_i; end
      ST_CLOSE:  begin strb_d = 1'b0; data_d = 1'b1;       end
      default:   begin strb_d = 1'b1; data_d = 1'b1;       end
    endcase
    busy_d = (state_d != ST_IDLE);
    done_d = (state_d == ST_DONE);
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kerr_q  <= 1'b0;
      perr_q  <= 1'b0;
      data_q  <= 1'b1;
      strb_q  <= 1'b1;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      kerr_q  <= kerr_d;
      perr_q  <= perr_d;
      data_q  <= data_d;
      strb_q  <= strb_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
    end
  end

  assign link_data_o   = data_q;
  assign link_strobe_o = strb_q;
  assign busy_o        = busy_q;
  assign done_o        = done_q;
  assign kbd_err_o     = kerr_q;
  assign par_err_o     = perr_q;

  // R1: idle lines parked high
  p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (strb_q && data_q && !busy_q));

  // R3: interrupt drives both lines low for the whole window
  p_intr_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_INTR) |-> (!strb_q && !data_q));

  // R4: data does not move while the strobe is low
  p_bit_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BIT_LO) |-> $stable(data_q));

  // R6: verdict phase holds strobe high and data released
  p_verdict_lines_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_VERDICT) |-> (strb_q && data_q));

  // R7: done lasts one cycle and is followed by idle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> (!done_q && !busy_q));

  // R2: a keyboard error only appears as the transfer ends
  p_err_at_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(kerr_q) |-> (state_q == ST_DONE));

endmodule

// File: rtl/kbd_cmd_tx.sv
module kbd_cmd_tx
  import kct_pkg::*;
#(
  parameter int DATA_W       = 4,
  parameter int READY_TO_CYC = 25_000_000,
  parameter int ACK_DLY_CYC  = 17_500,
  parameter int PHASE_CYC    = 2_500,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] cmd_i,
  input  logic              kbd_rdy_i,
  output logic              link_data_o,
  output logic              link_strobe_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              kbd_err_o,
  output logic              par_err_o
);

  localparam int FRAME_W = DATA_W + 1;
  localparam int CNT_MAX = kct_max3(READY_TO_CYC, ACK_DLY_CYC, PHASE_CYC);
  localparam int TMR_W   = $clog2(CNT_MAX + 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic             rdy_s;
  logic             tmr_load, tmr_expired;
  logic [TMR_W-1:0] tmr_val;
  logic             frame_load, frame_shift, bit_next, last_bit;

  kct_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .async_i (kbd_rdy_i),
    .sync_o  (rdy_s)
  );

  kct_timer #(.W(TMR_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .load_i    (tmr_load),
    .val_i     (tmr_val),
    .expired_o (tmr_expired)
  );

  kct_frame #(.W(FRAME_W)) u_frame (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .load_i     (frame_load),
    .shift_i    (frame_shift),
    .cmd_i      (cmd_i),
    .bit_next_o (bit_next),
    .last_o     (last_bit)
  );

  kct_ctrl #(
    .READY_TO_CYC (READY_TO_CYC),
    .ACK_DLY_CYC  (ACK_DLY_CYC),
    .PHASE_CYC    (PHASE_CYC),
    .TMR_W        (TMR_W)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_sync_q),
    .start_i       (start_i),
    .rdy_s_i       (rdy_s),
    .tmr_expired_i (tmr_expired),
    .bit_next_i    (bit_next),
    .last_bit_i    (last_bit),
    .tmr_load_o    (tmr_load),
    .tmr_val_o     (tmr_val),
    .frame_load_o  (frame_load),
    .frame_shift_o (frame_shift),
    .link_data_o   (link_data_o),
    .link_strobe_o (link_strobe_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .kbd_err_o     (kbd_err_o),
    .par_err_o     (par_err_o)
  );

endmodule

// File: tb/tb_kbd_cmd_tx.sv
module tb_kbd_cmd_tx;

  localparam int RDY_TO = 200;
  localparam int ACK_DL = 20;
  localparam int PHASE  = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] cmd = 4'h0;
  logic       dk = 1'b1;
  logic       data, strobe, busy, done, kerr, perr;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  kbd_cmd_tx #(
    .DATA_W(4), .READY_TO_CYC(RDY_TO), .ACK_DLY_CYC(ACK_DL), .PHASE_CYC(PHASE)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cmd_i(cmd), .kbd_rdy_i(dk),
    .link_data_o(data), .link_strobe_o(strobe), .busy_o(busy), .done_o(done),
    .kbd_err_o(kerr), .par_err_o(perr)
  );

  // {cmd, force_bad_verdict}
  localparam logic [4:0] VECS [0:5] = '{
    {4'hA, 1'b0}, {4'h0, 1'b0}, {4'hF, 1'b1},
    {4'h5, 1'b0}, {4'h8, 1'b1}, {4'h3, 1'b0}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] c);
    @(negedge clk);
    cmd   = c;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
  endtask

  // keyboard model: returns received frame and phase-length violations
  task automatic kbd_session(input bit bad, input bit ack,
                             output logic [4:0] frame, output int hi_bad, output int lo_bad);
    int n;
    frame = '0; hi_bad = 0; lo_bad = 0;
    n = 0;
    while (!(strobe == 1'b0 && data == 1'b0) && n < 1000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
    if (!ack) return;
    dk = 1'b0;
    for (int i = 0; i < 5; i++) begin
      n = 0;
      while (strobe == 1'b0 && n < 1000) begin @(negedge clk); n++; end
      n = 0;
      while (strobe == 1'b1 && n < 1000) begin @(negedge clk); n++; end
      if (n != PHASE) hi_bad++;
      frame = {frame[3:0], data};
      n = 0;
      while (strobe == 1'b0 && n < 1000) begin @(negedge clk); n++; end
      if (n != PHASE) lo_bad++;
    end
    dk = (^frame) ^ bad;
    n = 0;
    while (strobe == 1'b1 && n < 1000) begin
      if (data != 1'b1) lo_bad++;
      @(negedge clk); n++;
    end
    if (n != PHASE) hi_bad++;
    dk = 1'b1;
    n = 0;
    while (strobe == 1'b0 && n < 1000) begin @(negedge clk); n++; end
    if (n != PHASE) lo_bad++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog (all requirements): actual=expired expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [4:0] frame;
    int hb, lb, n, lows;

    // R1 reset state
    repeat (3) @(negedge clk);
    check(strobe && data && !busy && !done && !kerr && !perr, "R1", "lines during reset",
          {strobe, data, busy, done, kerr, perr}, 6'b110000);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(strobe && data && !busy, "R1", "idle after reset", {strobe, data, busy}, 3'b110);

    // table walk: R4 R5 R6 R7 R8
    foreach (VECS[i]) begin
      logic [3:0] c;
      bit bad;
      c = VECS[i][4:1];
      bad = VECS[i][0];
      send(c);
      check(!kerr && !perr && busy, "R8", "flags cleared on start", {kerr, perr, busy}, 3'b001);
      kbd_session(bad, 1'b1, frame, hb, lb);
      check(frame == {c, ~^c}, "R5", "frame bits MSB first with odd parity", frame, {c, ~^c});
      check(hb == 0, "R4", "strobe high phase length", hb, 0);
      check(lb == 0, "R4", "strobe low phase length / verdict data", lb, 0);
      wait_done(n);
      check(done == 1'b1, "R7", "done reached", done, 1);
      check(perr == bad, "R6", "parity verdict flag", perr, bad);
      check(kerr == 1'b0, "R3", "no keyboard error", kerr, 0);
      @(negedge clk);
      check(!done && !busy && strobe && data, "R7", "single done then idle",
            {done, busy, strobe, data}, 4'b0011);
      repeat (8) @(negedge clk);
      check(perr == bad, "R8", "verdict flag held", perr, bad);
    end

    // R2 ready timeout
    dk = 1'b0;
    repeat (5) @(negedge clk);
    send(4'h7);
    n = 1; lows = 0;
    while (!done && n < 2000) begin
      if (!strobe) lows++;
      @(negedge clk); n++;
    end
    check(n >= RDY_TO && n <= RDY_TO + 4, "R2", "timeout length", n, RDY_TO);
    check(kerr == 1'b1 && perr == 1'b0, "R2", "keyboard error flag", {kerr, perr}, 2'b10);
    check(lows == 0, "R2", "strobe never lowered", lows, 0);
    repeat (6) @(negedge clk);
    check(kerr == 1'b1, "R8", "keyboard error held", kerr, 1);

    // R3 missing acknowledge
    dk = 1'b1;
    repeat (5) @(negedge clk);
    send(4'hC);
    n = 0;
    while (strobe && n < 100) begin @(negedge clk); n++; end
    lows = 0;
    while (!strobe && !data && lows < 1000) begin @(negedge clk); lows++; end
    check(lows == ACK_DL, "R3", "interrupt window length", lows, ACK_DL);
    wait_done(n);
    check(kerr == 1'b1 && done == 1'b1, "R3", "no-ack error", {kerr, done}, 2'b11);
    @(negedge clk);
    check(strobe && data && !busy, "R3", "lines released after error", {strobe, data, busy}, 3'b110);

    // R8 start while busy ignored
    repeat (4) @(negedge clk);
    send(4'h6);
    send(4'h9);
    kbd_session(1'b0, 1'b1, frame, hb, lb);
    check(frame == 5'b0110_1, "R8", "second start ignored", frame, 5'b01101);
    wait_done(n);
    check(!kerr && !perr, "R8", "clean finish", {kerr, perr}, 0);

    // R1 reset in mid transfer
    repeat (4) @(negedge clk);
    send(4'h2);
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(strobe && data && !busy, "R1", "reset mid-transfer", {strobe, data, busy}, 3'b110);
    rst_n = 1'b1;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule